// File: doc/BRIEF.md
# Sprite Attribute Cache Snooper

This block keeps a small on-chip copy of the vertical attributes of every sprite in a sprite attribute table held in video memory. It does not rescan the table. It watches the video memory write port, and each write that lands on the cached part of a table entry updates that entry at once. A sprite evaluator that walks the table line by line therefore sees a table rewritten partway through a frame on the very next line, with no stale Y values left over.

The table has 80 entries of 8 bytes each and starts at a base byte address given on an input. Only the first 32-bit word of each entry is cached. The bytes of that word, at lane n = data bits [8n+7:8n], carry the fields as follows:

- byte 0: Y bits [7:0]
- byte 1 bits [1:0]: Y bits [9:8]
- byte 2 bits [3:0]: size code, with width-1 in bits [3:2] and height-1 in bits [1:0]
- byte 3 bits [6:0]: link

An interlace flag selects how the Y value is shown on the read port. Progressive mode uses 9 bits. Interlaced mode uses all 10 bits.

Top module: `sprite_attr_cache`

## Requirements
- R1: While rst_n is low at a rising clock edge, every entry is cleared. After reset, every index 0..79 reads back Y=0, width=0, height=0 and link=0.
- R2: A write with all four byte enables set, to a word-aligned address base+8*i (i < 80), replaces all fields of entry i. The read port shows the new values from the clock edge that takes the write onward. The field layout is the one given above.
- R3: Each byte enable updates only its own byte of the entry. Lane 0 sets Y[7:0], lane 1 sets Y[9:8], lane 2 sets the size code and lane 3 sets the link. Fields whose lane is disabled keep their value.
- R4: A write whose address is below the table base, or at or above base+640, changes no entry.
- R5: A write to the second word of an entry (address offset 4 to 7 within the entry) changes no entry.
- R6: With interlace=0, rd_ypos is {0, Y[8:0]}. With interlace=1, rd_ypos is the full 10-bit Y. The mode affects only the read view and never the stored value.
- R7: When a write to entry i and a read of index i happen in the same cycle, the read port already shows the merged new data in that cycle.
- R8: Changing tbl_base does not reload or clear any entry. Later writes are decoded against the new base.
- R9: A read index of 80 or above returns all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Video memory write strobe |
| wr_addr | input | 16 | Byte address of the write; bits [1:0] are ignored (word writes) |
| wr_data | input | 32 | Write data, byte lane n holds byte offset n |
| wr_be | input | 4 | Byte enables, one per lane |
| tbl_base | input | 16 | Byte address of table entry 0, 8-byte aligned |
| interlace | input | 1 | 1 = interlaced Y view, 0 = progressive |
| rd_idx | input | 7 | Sprite index to read |
| rd_ypos | output | 10 | Y position of the sprite, as viewed in the current mode |
| rd_width | output | 2 | Width in tiles minus one |
| rd_height | output | 2 | Height in tiles minus one |
| rd_link | output | 7 | Link field |

## Verification
The assertions check the following on every cycle:

- the progressive view never shows Y bit 9;
- out-of-range indices read as zero;
- a same-cycle write shows through to the read of the same entry;
- a write that hit shows up in the link on the following cycle;
- the outputs hold steady while no decoded hit occurs.

Only the bench scenarios can show the rest. These are the exact byte-lane merge sequences on one entry, the boundary addresses just below the base and at base+640, writes to an entry's second word, the retention of entries across a base change followed by decoding against the new base, and clearing by a second reset after the cache was filled.

// File: rtl/sac_pkg.sv
`timescale 1ns/1ps
// Package: field widths, cached-entry type and the byte-lane merge rule
// shared by the sprite attribute cache modules.
package sac_pkg;
    localparam int Y_W    = 10;
    localparam int SZ_W   = 4;
    localparam int LK_W   = 7;
    localparam int LANES  = 4;
    localparam int DATA_W = LANES * 8;

    typedef struct packed {
        logic [Y_W-1:0]  y;
        logic [SZ_W-1:0] sz;
        logic [LK_W-1:0] lk;
    } spr_ent_t;

    // Merge one write word into an entry, lane by lane.
    function automatic spr_ent_t merge_word(spr_ent_t old_e,
                                            logic [DATA_W-1:0] d,
                                            logic [LANES-1:0] be);
        spr_ent_t n;
        n = old_e;
        if (be[0]) n.y[7:0]     = d[7:0];
        if (be[1]) n.y[Y_W-1:8] = d[8 +: (Y_W-8)];
        if (be[2]) n.sz         = d[16 +: SZ_W];
        if (be[3]) n.lk         = d[24 +: LK_W];
        return n;
    endfunction
endpackage

// File: rtl/sac_decode.sv
`timescale 1ns/1ps
// Module: sac_decode
// Decides whether a video memory write lands on the cached word of a table
// entry and, if so, which entry. Assumes tbl_base is ENTRY_BYTES aligned and
// ENTRY_BYTES is a power of two. Address bits below the word are ignored.
module sac_decode #(
    parameter int ADDR_W       = 16,
    parameter int NUM_SPR      = 80,
    parameter int ENTRY_BYTES  = 8,
    parameter int CACHED_BYTES = 4,
    parameter int IDX_W        = $clog2(NUM_SPR)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int EOFF_W = $clog2(ENTRY_BYTES);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_SPR * ENTRY_BYTES);
    localparam logic [EOFF_W-1:0] CLIM = EOFF_W'(CACHED_BYTES);

    logic [ADDR_W-1:0] offset;

    // Offset from the base; an address below the base wraps to a large value.
    always_comb begin
        offset = wr_addr - tbl_base;
        hit    = wr_en && (offset < SPAN) && (offset[EOFF_W-1:0] < CLIM);
        idx    = IDX_W'(offset >> EOFF_W);
    end
endmodule

// File: rtl/sac_store.sv
`timescale 1ns/1ps
// Module: sac_store
// Entry storage with byte-lane writes and a read port that forwards a
// same-cycle write to the entry being read. READ_REG selects a purely
// combinational read (0) or a read registered by one cycle (1).
// Assumes wr_idx < NUM_SPR whenever wr_hit is set.
module sac_store
    import sac_pkg::*;
#(
    parameter int NUM_SPR  = 80,
    parameter int IDX_W    = $clog2(NUM_SPR),
    parameter bit READ_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [IDX_W-1:0]  rd_idx,
    output spr_ent_t          rd_ent
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SPR - 1);

    spr_ent_t mem [NUM_SPR];
    spr_ent_t raw;
    spr_ent_t fwd;

    // Clear on reset; otherwise merge a hitting write into its entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SPR; i++) mem[i] <= '0;
        end else if (wr_hit) begin
            mem[wr_idx] <= merge_word(mem[wr_idx], wr_data, wr_be);
        end
    end

    // Fetch the addressed entry and overlay a write to the same entry.
    always_comb begin
        raw = (rd_idx <= LAST) ? mem[rd_idx] : '0;
        fwd = raw;
        if (wr_hit && (wr_idx == rd_idx)) fwd = merge_word(raw, wr_data, wr_be);
    end

    generate
        if (READ_REG) begin : g_rd_reg
            spr_ent_t rd_q;
            // Register the forwarded read result.
            always_ff @(posedge clk) begin
                if (!rst_n) rd_q <= '0;
                else        rd_q <= fwd;
            end
            assign rd_ent = rd_q;
        end else begin : g_rd_comb
            assign rd_ent = fwd;
        end
    endgenerate
endmodule

// File: rtl/sac_view.sv
`timescale 1ns/1ps
// Module: sac_view
// Presents a cached entry to the evaluator. Progressive mode hides the top
// Y bit; interlaced mode shows the full Y. The size code splits into width
// and height, each in tiles minus one.
module sac_view
    import sac_pkg::*;
(
    input  spr_ent_t         ent,
    input  logic             interlace,
    output logic [Y_W-1:0]   ypos,
    output logic [1:0]       width,
    output logic [1:0]       height,
    output logic [LK_W-1:0]  link
);
    // Mode-dependent Y view and size field split.
    always_comb begin
        ypos   = interlace ? ent.y : {1'b0, ent.y[Y_W-2:0]};
        width  = ent.sz[3:2];
        height = ent.sz[1:0];
        link   = ent.lk;
    end
endmodule

// File: rtl/sprite_attr_cache.sv
`timescale 1ns/1ps
// Module: sprite_attr_cache (top)
// Snoops video memory writes and keeps Y, size and link of every sprite
// table entry up to date, so table rewrites take effect on the next read.
// Assumes word-aligned writes and an 8-byte aligned table base.
module sprite_attr_cache
    import sac_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int NUM_SPR      = 80,
    parameter int ENTRY_BYTES  = 8,
    parameter int CACHED_BYTES = 4,
    parameter int IDX_W        = $clog2(NUM_SPR),
    parameter bit READ_REG     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              interlace,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [9:0]        rd_ypos,
    output logic [1:0]        rd_width,
    output logic [1:0]        rd_height,
    output logic [6:0]        rd_link
);
    logic             hit;
    logic [IDX_W-1:0] widx;
    spr_ent_t         ent;

    sac_decode #(
        .ADDR_W(ADDR_W), .NUM_SPR(NUM_SPR), .ENTRY_BYTES(ENTRY_BYTES),
        .CACHED_BYTES(CACHED_BYTES), .IDX_W(IDX_W)
    ) dec_i (
        .wr_en(wr_en), .wr_addr(wr_addr), .tbl_base(tbl_base),
        .hit(hit), .idx(widx)
    );

    sac_store #(
        .NUM_SPR(NUM_SPR), .IDX_W(IDX_W), .READ_REG(READ_REG)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit), .wr_idx(widx),
        .wr_data(wr_data), .wr_be(wr_be), .rd_idx(rd_idx), .rd_ent(ent)
    );

    sac_view view_i (
        .ent(ent), .interlace(interlace), .ypos(rd_ypos),
        .width(rd_width), .height(rd_height), .link(rd_link)
    );
endmodule

// File: rtl/sprite_attr_cache_chk.sv
`timescale 1ns/1ps
// Module: sprite_attr_cache_chk
// Port-level checker bound to sprite_attr_cache. It decodes hits on its own
// and assumes the default combinational read (READ_REG = 0).
module sprite_attr_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [3:0]        wr_be,
    input logic [ADDR_W-1:0] tbl_base,
    input logic              interlace,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [9:0]        rd_ypos,
    input logic [1:0]        rd_width,
    input logic [1:0]        rd_height,
    input logic [6:0]        rd_link
);
    logic [ADDR_W-1:0] c_off;
    logic              c_hit;
    logic [IDX_W-1:0]  c_idx;

    // Independent decode of the table window.
    always_comb begin
        c_off = wr_addr - tbl_base;
        c_hit = wr_en && (c_off < ADDR_W'(640)) && !c_off[2];
        c_idx = c_off[IDX_W+2:3];
    end

    // R6
    prog_ybit9_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace |-> !rd_ypos[9]);

    // R9
    range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx > IDX_W'(79)) |-> (rd_ypos == '0 && rd_width == '0 &&
                                   rd_height == '0 && rd_link == '0));

    // R7
    same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && wr_be[3] && rd_idx == c_idx) |-> (rd_link == wr_data[30:24]));

    // R2
    next_cycle_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(c_hit && wr_be[3]) && rd_idx == $past(c_idx) && !c_hit)
        |-> (rd_link == $past(wr_data[30:24])));

    // R4 R5
    no_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(c_hit) && !c_hit && $stable(rd_idx) && $stable(interlace))
        |-> ($stable(rd_ypos) && $stable(rd_width) && $stable(rd_height) && $stable(rd_link)));
endmodule

bind sprite_attr_cache sprite_attr_cache_chk chk_i (.*);

// File: tb/sprite_attr_cache_tb_top.sv
`timescale 1ns/1ps
// Bench for sprite_attr_cache: a vector table of writes and expected
// entry contents, then directed tests for reset, mode, forwarding and base.
module sprite_attr_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [15:0] tbl_base;
    logic        interlace;
    logic [6:0]  rd_idx;
    logic [9:0]  rd_ypos;
    logic [1:0]  rd_width;
    logic [1:0]  rd_height;
    logic [6:0]  rd_link;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sprite_attr_cache dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .tbl_base(tbl_base),
        .interlace(interlace), .rd_idx(rd_idx), .rd_ypos(rd_ypos),
        .rd_width(rd_width), .rd_height(rd_height), .rd_link(rd_link)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        logic [6:0]  idx;
        logic [9:0]  y;
        logic [3:0]  sz;
        logic [6:0]  lk;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{16'h1000, 32'h050B0234, 4'hF, 7'd0,  10'h234, 4'hB, 7'h05, 4'd2}, // R2 first entry
        '{16'h1278, 32'h4F0601FF, 4'hF, 7'd79, 10'h1FF, 4'h6, 7'h4F, 4'd2}, // R2 last entry
        '{16'h1008, 32'hFFFFFFFF, 4'hF, 7'd1,  10'h3FF, 4'hF, 7'h7F, 4'd2}, // R2 all ones
        '{16'h1008, 32'h00000012, 4'h1, 7'd1,  10'h312, 4'hF, 7'h7F, 4'd3}, // R3 lane 0
        '{16'h1008, 32'h02000000, 4'h8, 7'd1,  10'h312, 4'hF, 7'h02, 4'd3}, // R3 lane 3
        '{16'h1008, 32'h00030000, 4'h4, 7'd1,  10'h312, 4'h3, 7'h02, 4'd3}, // R3 lane 2
        '{16'h1008, 32'h00000100, 4'h2, 7'd1,  10'h112, 4'h3, 7'h02, 4'd3}, // R3 lane 1
        '{16'h1014, 32'hFFFFFFFF, 4'hF, 7'd2,  10'h000, 4'h0, 7'h00, 4'd5}, // R5 second word
        '{16'h0FF8, 32'hFFFFFFFF, 4'hF, 7'd0,  10'h234, 4'hB, 7'h05, 4'd4}, // R4 below base
        '{16'h1280, 32'hFFFFFFFF, 4'hF, 7'd79, 10'h1FF, 4'h6, 7'h4F, 4'd4}  // R4 end of window
    };

    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic check_ent(input logic [6:0] idx, input logic [9:0] ey,
                             input logic [3:0] es, input logic [6:0] el, input string tag);
        rd_idx = idx;
        #1;
        checks++;
        if ({rd_ypos, rd_width, rd_height, rd_link} !== {ey, es, el}) begin
            errors++;
            $display("FAIL %s idx=%0d actual y=%h sz=%h lk=%h expected y=%h sz=%h lk=%h",
                     tag, idx, rd_ypos, {rd_width, rd_height}, rd_link, ey, es, el);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
        tbl_base = 16'h1000; interlace = 1'b1; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_ent(7'd0,  10'h0, 4'h0, 7'h0, "R1");
        check_ent(7'd79, 10'h0, 4'h0, 7'h0, "R1");

        // Vector table: one write, then a read of the affected entry.
        for (int i = 0; i < NV; i++) begin
            do_write(TBL[i].a, TBL[i].d, TBL[i].be);
            check_ent(TBL[i].idx, TBL[i].y, TBL[i].sz, TBL[i].lk,
                      $sformatf("R%0d vec%0d", TBL[i].rq, i));
        end

        // R6 progressive view hides Y bit 9
        interlace = 1'b0;
        check_ent(7'd0,  10'h034, 4'hB, 7'h05, "R6");
        check_ent(7'd79, 10'h1FF, 4'h6, 7'h4F, "R6");
        interlace = 1'b1;
        check_ent(7'd0,  10'h234, 4'hB, 7'h05, "R6");

        // R7 same-cycle write and read of entry 3
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h1018; wr_data = 32'h110C0321; wr_be = 4'hF;
        check_ent(7'd3, 10'h321, 4'hC, 7'h11, "R7 same cycle");
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
        check_ent(7'd3, 10'h321, 4'hC, 7'h11, "R7 after edge");

        // R8 base change keeps contents; decode follows the new base
        @(negedge clk);
        tbl_base = 16'h2000;
        check_ent(7'd0, 10'h234, 4'hB, 7'h05, "R8 retained");
        do_write(16'h1000, 32'h00000000, 4'hF);
        check_ent(7'd0, 10'h234, 4'hB, 7'h05, "R8 old base miss");
        do_write(16'h2010, 32'h33050040, 4'hF);
        check_ent(7'd2, 10'h040, 4'h5, 7'h33, "R8 new base");

        // R9 indices past the table read zero
        check_ent(7'd80,  10'h0, 4'h0, 7'h0, "R9");
        check_ent(7'd127, 10'h0, 4'h0, 7'h0, "R9");

        // R1 a second reset clears filled entries
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_ent(7'd0, 10'h0, 4'h0, 7'h0, "R1 re-reset");
        check_ent(7'd3, 10'h0, 4'h0, 7'h0, "R1 re-reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule